// File: doc/BRIEF.md
# Cell-Store Refresh Scheduler

This block keeps a DRAM-based cell store alive. The store has a fixed number of row locations (8192 by default). Each one must be refreshed within a bounded time, whether it holds a queued cell or is free. A programmable interval timer marks the moments when one more refresh is owed. Each mark adds one to a backlog counter. An arbiter places owed refreshes on the shared command bus only in slots that no cell transfer wants.

The refresh command carries no row address. A memory-side row counter watches the command bus. It steps to the next row on every refresh command and wraps after the last row. It reports each completed sweep of the whole store with a one-cycle flag. A programmable urgency threshold handles a backlog that grows because the bus stays busy. While the backlog is at or above the threshold, refresh takes the bus ahead of cell transfers.

Top module: `cellstore_refresh_sched`

## Requirements
- R1: During and right after synchronous reset, `cmd_code` is 0 (idle), `backlog` is 0, `row_addr` is 0 and `sweep_done` is 0.
- R2: With `interval` = N > 0, the timer raises one owed refresh every N clock cycles. The first one arrives at the Nth rising edge after reset is released, and it appears in `backlog` from that edge.
- R3: With `interval` = 0, no refresh is ever owed: `backlog` stays 0 and no refresh command appears.
- R4: When the backlog is below the urgency threshold, or the threshold is 0, a cycle with `xfer_req` high produces the transfer code 1 on `cmd_code` one cycle later, and `backlog` is not decremented.
- R5: When `backlog` is nonzero and `xfer_req` is low, the refresh code 2 appears on `cmd_code` one cycle later, and `backlog` drops by one in that same edge. A tick in that edge cancels the decrement.
- R6: When `urgent_lvl` is nonzero and `backlog` ≥ `urgent_lvl`, refresh code 2 is issued even while `xfer_req` is high, and the transfer waits.
- R7: The command bus is a 2-bit code with no address field: 0 = idle, 1 = cell transfer, 2 = refresh.
- R8: The row counter advances by one in the cycle after each refresh code on the bus. It wraps from ROWS-1 to 0, and `sweep_done` is high for exactly the one cycle in which the wrap becomes visible.
- R9: `backlog` saturates at 2^BL_W - 1. A tick that arrives while it is full and nothing is issued is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| interval | input | IVAL_W | Cycles between owed refreshes; 0 disables |
| urgent_lvl | input | BL_W | Backlog level that gives refresh priority; 0 never |
| xfer_req | input | 1 | Cell transfer wants the next command slot |
| cmd_code | output | 2 | Registered command: 0 idle, 1 transfer, 2 refresh |
| backlog | output | BL_W | Owed refreshes not yet issued |
| row_addr | output | log2(ROWS) | Memory-side refresh row pointer |
| sweep_done | output | 1 | One-cycle pulse when the row pointer wraps |

## Verification
A wrong timer count shifts the cycle in which `backlog` steps up. This is visible at the ports within one interval. A wrong backlog or arbitration decision changes `cmd_code` on the very next cycle. The mistake then stays visible in `backlog`, because each error there persists until the next refresh or tick. A faulty row counter misplaces the `sweep_done` pulse, which can only be seen after a full sweep of ROWS refreshes. For this reason the bench uses a 16-row store, so that several wraps fit into each run.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE    = 2'd0,
    CMD_XFER    = 2'd1,
    CMD_REFRESH = 2'd2
  } cmd_e;
endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int IVAL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IVAL_W-1:0] interval,
  output logic              tick
);
  logic [IVAL_W-1:0] tcnt;

  assign tick = (interval != '0) && (tcnt >= interval - IVAL_W'(1));

  always_ff @(posedge clk) begin
    if (rst || interval == '0 || tick) tcnt <= '0;
    else                               tcnt <= tcnt + IVAL_W'(1);
  end

  p_held_when_off_r3: assert property (@(posedge clk) disable iff (rst)
    (interval == '0) |=> (tcnt == '0));
  p_count_bounded_r2: assert property (@(posedge clk) disable iff (rst)
    (interval != '0 && $stable(interval)) |-> (tcnt < interval));
endmodule

// File: rtl/refresh_backlog.sv
module refresh_backlog #(
  parameter int BL_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            issue,
  output logic [BL_W-1:0] pend
);
  localparam logic [BL_W-1:0] BL_MAX = {BL_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                             pend <= '0;
    else if (tick && !issue && pend != BL_MAX) pend <= pend + BL_W'(1);
    else if (!tick && issue)             pend <= pend - BL_W'(1);
  end

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (pend == BL_MAX && !issue) |=> (pend == BL_MAX));
  p_unit_step_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pend == $past(pend) || pend == $past(pend) + BL_W'(1) ||
              pend == $past(pend) - BL_W'(1)));
endmodule

// File: rtl/refresh_arbiter.sv
module refresh_arbiter
  import refresh_pkg::*;
#(
  parameter int BL_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BL_W-1:0] pend,
  input  logic [BL_W-1:0] urgent_lvl,
  input  logic            xfer_req,
  output logic            issue,
  output cmd_e            cmd
);
  logic urgent;

  assign urgent = (urgent_lvl != '0) && (pend >= urgent_lvl);
  assign issue  = (pend != '0) && (!xfer_req || urgent);

  always_ff @(posedge clk) begin
    if (rst)           cmd <= CMD_IDLE;
    else if (issue)    cmd <= CMD_REFRESH;
    else if (xfer_req) cmd <= CMD_XFER;
    else               cmd <= CMD_IDLE;
  end

  p_refresh_owed_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REFRESH) |-> ($past(pend) != '0));
  p_urgent_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (urgent && xfer_req) |=> (cmd == CMD_REFRESH));
  p_xfer_served_r4: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !urgent) |=> (cmd == CMD_XFER));
  p_legal_code_r7: assert property (@(posedge clk) disable iff (rst)
    cmd != 2'd3);
endmodule

// File: rtl/refresh_row_counter.sv
module refresh_row_counter
  import refresh_pkg::*;
#(
  parameter int ROWS = 8192,
  localparam int ADDR_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_e              bus_cmd,
  output logic [ADDR_W-1:0] row,
  output logic              sweep
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(ROWS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      row   <= '0;
      sweep <= 1'b0;
    end else if (bus_cmd == CMD_REFRESH) begin
      row   <= (row == LAST) ? '0 : row + ADDR_W'(1);
      sweep <= (row == LAST);
    end else begin
      sweep <= 1'b0;
    end
  end

  p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == CMD_REFRESH && row == LAST) |=> (row == '0 && sweep));
  p_sweep_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    sweep |=> !sweep);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd != CMD_REFRESH) |=> $stable(row));
endmodule

// File: rtl/cellstore_refresh_sched.sv
module cellstore_refresh_sched
  import refresh_pkg::*;
#(
  parameter int ROWS   = 8192,
  parameter int IVAL_W = 16,
  parameter int BL_W   = 4,
  localparam int ADDR_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IVAL_W-1:0] interval,
  input  logic [BL_W-1:0]   urgent_lvl,
  input  logic              xfer_req,
  output logic [1:0]        cmd_code,
  output logic [BL_W-1:0]   backlog,
  output logic [ADDR_W-1:0] row_addr,
  output logic              sweep_done
);
  logic tick;
  logic issue;
  cmd_e cmd;

  refresh_timer #(.IVAL_W(IVAL_W)) u_timer (
    .clk(clk), .rst(rst), .interval(interval), .tick(tick)
  );

  refresh_backlog #(.BL_W(BL_W)) u_backlog (
    .clk(clk), .rst(rst), .tick(tick), .issue(issue), .pend(backlog)
  );

  refresh_arbiter #(.BL_W(BL_W)) u_arb (
    .clk(clk), .rst(rst), .pend(backlog), .urgent_lvl(urgent_lvl),
    .xfer_req(xfer_req), .issue(issue), .cmd(cmd)
  );

  refresh_row_counter #(.ROWS(ROWS)) u_rows (
    .clk(clk), .rst(rst), .bus_cmd(cmd), .row(row_addr), .sweep(sweep_done)
  );

  assign cmd_code = cmd;

  p_off_no_refresh_r3: assert property (@(posedge clk) disable iff (rst)
    (interval == '0 && backlog == '0) |=> (backlog == '0));
endmodule

// File: tb/sim_cellstore_refresh_sched.sv
module sim_cellstore_refresh_sched;
  localparam int ROWS = 16;
  localparam int IVAL_W = 4;
  localparam int BL_W = 3;
  localparam int ADDR_W = $clog2(ROWS);
  localparam int BL_MAX = (1 << BL_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IVAL_W-1:0] interval = '0;
  logic [BL_W-1:0] urgent_lvl = '0;
  logic xfer_req = 1'b0;
  logic [1:0] cmd_code;
  logic [BL_W-1:0] backlog;
  logic [ADDR_W-1:0] row_addr;
  logic sweep_done;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // reference state, derived from the requirements
  int m_t = 0, m_pend = 0, m_cmd = 0, m_row = 0, m_sw = 0;

  always #4 clk = ~clk;

  cellstore_refresh_sched #(.ROWS(ROWS), .IVAL_W(IVAL_W), .BL_W(BL_W)) u0 (
    .clk(clk), .rst(rst), .interval(interval), .urgent_lvl(urgent_lvl),
    .xfer_req(xfer_req), .cmd_code(cmd_code), .backlog(backlog),
    .row_addr(row_addr), .sweep_done(sweep_done)
  );

  always @(posedge clk) begin
    int iv, tk, urg, iss, nt, np, nc, nr, ns;
    if (rst) begin
      m_t = 0; m_pend = 0; m_cmd = 0; m_row = 0; m_sw = 0;
    end else begin
      iv  = int'(interval);
      tk  = (iv != 0 && m_t >= iv - 1) ? 1 : 0;
      nt  = (iv == 0 || tk == 1) ? 0 : m_t + 1;
      urg = (urgent_lvl != 0 && m_pend >= int'(urgent_lvl)) ? 1 : 0;
      iss = (m_pend != 0 && (!xfer_req || urg == 1)) ? 1 : 0;
      nc  = iss ? 2 : (xfer_req ? 1 : 0);
      np  = m_pend + tk - iss;
      if (np > BL_MAX) np = BL_MAX;
      if (m_cmd == 2) begin
        nr = (m_row == ROWS - 1) ? 0 : m_row + 1;
        ns = (m_row == ROWS - 1) ? 1 : 0;
      end else begin
        nr = m_row; ns = 0;
      end
      m_t = nt; m_pend = np; m_cmd = nc; m_row = nr; m_sw = ns;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(cur_req, "cmd_code", int'(cmd_code), m_cmd);
    chk(cur_req, "backlog", int'(backlog), m_pend);
    chk(cur_req, "row_addr", int'(row_addr), m_row);
    chk(cur_req, "sweep_done", int'(sweep_done), m_sw);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    steps(2);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    // R1: reset state
    cur_req = "R1";
    do_reset();
    chk("R1", "cmd_code", int'(cmd_code), 0);
    chk("R1", "backlog", int'(backlog), 0);
    chk("R1", "row_addr", int'(row_addr), 0);
    chk("R1", "sweep_done", int'(sweep_done), 0);

    // R3: interval 0 disables refresh
    cur_req = "R3";
    interval = 0; xfer_req = 1'b0;
    steps(200);
    chk("R3", "backlog", int'(backlog), 0);
    chk("R3", "cmd_code", int'(cmd_code), 0);

    // R2 / R4: ticks every 5 cycles, transfers always win
    cur_req = "R2";
    do_reset();
    interval = 5; urgent_lvl = 0; xfer_req = 1'b1;
    steps(4);
    chk("R2", "backlog before 5th edge", int'(backlog), 0);
    steps(11);
    chk("R2", "backlog after 15 edges", int'(backlog), 3);
    chk("R4", "cmd_code transfer", int'(cmd_code), 1);
    // R9: saturation (65 edges give 13 ticks)
    cur_req = "R9";
    steps(50);
    chk("R9", "backlog saturated", int'(backlog), BL_MAX);

    // R5 / R7: free slot gives refresh code 2
    cur_req = "R5";
    xfer_req = 1'b0;
    step();
    chk("R5", "cmd_code refresh", int'(cmd_code), 2);
    chk("R7", "refresh code value", int'(cmd_code), 2);
    steps(20);

    // R6: urgency threshold 3, interval 2, transfers always requested
    cur_req = "R6";
    do_reset();
    interval = 2; urgent_lvl = 3; xfer_req = 1'b1;
    steps(6);
    chk("R6", "backlog at threshold", int'(backlog), 3);
    chk("R6", "cmd_code before urgent", int'(cmd_code), 1);
    step();
    chk("R6", "urgent refresh", int'(cmd_code), 2);
    chk("R6", "backlog after urgent", int'(backlog), 2);
    steps(30);

    // R8: refresh every cycle, wrap after 16 rows
    cur_req = "R8";
    do_reset();
    interval = 1; urgent_lvl = 0; xfer_req = 1'b0;
    steps(17);
    chk("R8", "row before wrap", int'(row_addr), 15);
    step();
    chk("R8", "sweep on wrap", int'(sweep_done), 1);
    chk("R8", "row after wrap", int'(row_addr), 0);
    step();
    chk("R8", "sweep one cycle", int'(sweep_done), 0);
    chk("R8", "row advances", int'(row_addr), 1);
    steps(40);

    // near-exhaustive sweep of interval and threshold with mixed traffic
    for (int iv = 0; iv < 8; iv++) begin
      for (int ul = 0; ul < 5; ul++) begin
        cur_req = (ul == 0) ? "R4" : "R6";
        do_reset();
        interval = IVAL_W'(iv);
        urgent_lvl = BL_W'(ul);
        for (int c = 0; c < 60; c++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          xfer_req = (lfsr[1:0] != 2'b00);
          step();
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule